// File: doc/BRIEF.md
# Doorbell Inter-Processor and Message Interrupt Trigger Unit

This block holds a set of doorbell bits for each of several CPUs and raises them from a single shared trigger write. One trigger word names a doorbell and a bitmap of target CPUs, and the named doorbell becomes pending in the cause register of every targeted CPU. The same path serves two uses. Software on one CPU can interrupt other CPUs (inter-processor interrupts). Devices can post message-signalled interrupts by writing a trigger word, which lands in the upper doorbell group.

Each CPU reaches its own cause and mask registers through a banked register port. A CPU-number sideband picks the bank. Pending doorbells are summarised per CPU into two level interrupt lines, one for the inter-processor group (doorbells 7..0) and one for the message group (doorbells 31..16). A doorbell is cleared by writing a zero into its cause bit. Writing a one leaves the bit as it is, so a handler can clear exactly the doorbells it has serviced.

The register port has a small read sequencer with two states. `PORT_IDLE` is the state with no response pending. `PORT_RESP` drives the read data for one cycle. The transitions are:
- idle-to-resp, taken on a read request;
- resp-to-resp, taken on a back-to-back read;
- resp-to-idle, taken when no read follows.

Top module: `dbell_unit`

## Requirements
- R1: After reset, every cause and mask register is zero, every summary line is low and `reg_rvalid` is low.
- R2: A cycle with `trig_we` high, where `trig_wdata[4:0]` = n is in a doorbell group, sets cause bit n of every CPU c whose bit `trig_wdata[8+c]` is 1. It leaves all other cause bits and all other CPUs unchanged, and the bit is visible from the next cycle.
- R3: A trigger whose doorbell number is 8..15 changes no cause register on any CPU.
- R4: A register write to byte offset 0x8 on CPU c replaces its cause with `cause & wdata`. Bits written 0 are cleared, and bits written 1 keep their value and are never set by the write.
- R5: When a trigger sets bit n of a CPU in the same cycle as a cause write clears that bit, the bit ends up set.
- R6: A register write to byte offset 0xC on CPU c replaces its mask with `wdata`, and a read of 0xC returns it.
- R7: `ipi_irq[c]` is high exactly when some bit in 7..0 is set in both cause and mask of CPU c.
- R8: `msi_irq[c]` is high exactly when some bit in 31..16 is set in both cause and mask of CPU c.
- R9: A read request (`reg_valid` high, `reg_write` low) makes `reg_rvalid` high in the next cycle with `reg_rdata` holding the addressed register. For offset 0x8 this is the raw pending bits whatever the mask holds. Any offset other than 0x8 or 0xC reads 0, and writes to such offsets change nothing.
- R10: A register access affects only the CPU selected by `reg_cpu`.
- R11: Writing 0 to both mask and cause of a CPU brings both of its summary lines low and clears all of its doorbells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_we | input | 1 | Trigger write strobe |
| trig_wdata | input | 32 | Trigger word: doorbell number [4:0], target bitmap [11:8] |
| reg_valid | input | 1 | Per-CPU register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset: 0x8 cause, 0xC mask |
| reg_cpu | input | 2 | CPU number selecting the register bank |
| reg_wdata | input | 32 | Register write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| reg_rdata | output | 32 | Read data |
| ipi_irq | output | 4 | Inter-processor group summary line per CPU |
| msi_irq | output | 4 | Message group summary line per CPU |

## Verification
The assertions assume that every input is a known value at each rising edge after reset. They also assume that a read request is one that, while held, is answered in the following cycle, so the response-valid check only looks one cycle back. The bench changes inputs only on falling edges and drives only defined values. It sweeps every doorbell number against every target bitmap and every mask pattern of interest. It never leaves a request strobe high longer than the access it describes.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
    typedef enum logic [0:0] {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;

    typedef enum logic [1:0] {
        REG_NONE  = 2'd0,
        REG_CAUSE = 2'd1,
        REG_MASK  = 2'd2
    } reg_sel_e;

    localparam logic [3:0] CAUSE_OFS = 4'h8;
    localparam logic [3:0] MASK_OFS  = 4'hC;
endpackage

// File: rtl/dbell_trig_decode.sv
module dbell_trig_decode #(
    parameter int NUM_CPUS = 4,
    parameter int DB_W     = 32,
    parameter int TGT_LSB  = 8,
    parameter logic [DB_W-1:0] GROUP_SPAN = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          trig_we,
    input  logic [DB_W-1:0]               trig_wdata,
    output logic [NUM_CPUS-1:0][DB_W-1:0] set_vec
);
    localparam int NUM_W = $clog2(DB_W);

    logic [NUM_W-1:0] db_num;
    logic [DB_W-1:0]  db_onehot;
    logic [NUM_CPUS-1:0] tgt_map;

    always_comb begin
        db_num    = trig_wdata[NUM_W-1:0];
        tgt_map   = trig_wdata[TGT_LSB +: NUM_CPUS];
        db_onehot = (DB_W'(1) << db_num) & GROUP_SPAN;
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        assign set_vec[c] = (trig_we && tgt_map[c]) ? db_onehot : '0;

        // R2: a trigger raises at most one doorbell per CPU
        a_r2_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(set_vec[c]));
        // R3: numbers outside both groups reach no cause register
        a_r3_gap_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_we && !GROUP_SPAN[db_num]) |-> (set_vec[c] == '0));
    end
endmodule

// File: rtl/dbell_cpu_bank.sv
module dbell_cpu_bank #(
    parameter int DB_W = 32,
    parameter logic [DB_W-1:0] IPI_SPAN = '0,
    parameter logic [DB_W-1:0] MSI_SPAN = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] set_i,
    input  logic            cause_we,
    input  logic            mask_we,
    input  logic [DB_W-1:0] wdata,
    output logic [DB_W-1:0] cause_o,
    output logic [DB_W-1:0] mask_o,
    output logic            ipi_irq_o,
    output logic            msi_irq_o
);
    logic [DB_W-1:0] cause_q, cause_d;
    logic [DB_W-1:0] mask_q;
    logic [DB_W-1:0] live;

    always_comb begin
        if (cause_we) cause_d = (cause_q & wdata) | set_i;
        else          cause_d = cause_q | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '0;
        end else begin
            cause_q <= cause_d;
            if (mask_we) mask_q <= wdata;
        end
    end

    always_comb begin
        live      = cause_q & mask_q;
        ipi_irq_o = |(live & IPI_SPAN);
        msi_irq_o = |(live & MSI_SPAN);
        cause_o   = cause_q;
        mask_o    = mask_q;
    end

    // R5: a raised doorbell is pending in the next cycle, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((cause_q & $past(set_i)) == $past(set_i)));
    // R4: no cause bit appears without a trigger
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((cause_q & ~$past(cause_q)) == '0));
    // R6: the mask only moves on a mask write
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/dbell_regport.sv
module dbell_regport
    import dbell_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int DB_W     = 32,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [3:0]                    req_addr,
    input  logic [CPU_W-1:0]              req_cpu,
    input  logic [NUM_CPUS-1:0][DB_W-1:0] cause_all,
    input  logic [NUM_CPUS-1:0][DB_W-1:0] mask_all,
    output logic [NUM_CPUS-1:0]           cause_we,
    output logic [NUM_CPUS-1:0]           mask_we,
    output logic                          rd_valid,
    output logic [DB_W-1:0]               rd_data
);
    port_state_e state_q, state_d;
    reg_sel_e    sel;
    logic        rd_req;
    logic [DB_W-1:0] rd_mux;

    always_comb begin
        sel = REG_NONE;
        if (req_addr == CAUSE_OFS)     sel = REG_CAUSE;
        else if (req_addr == MASK_OFS) sel = REG_MASK;
        rd_req = req_valid && !req_write;
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            cause_we[c] = req_valid && req_write && (sel == REG_CAUSE) && (req_cpu == CPU_W'(c));
            mask_we[c]  = req_valid && req_write && (sel == REG_MASK)  && (req_cpu == CPU_W'(c));
            if (req_cpu == CPU_W'(c)) begin
                if (sel == REG_CAUSE)     rd_mux = cause_all[c];
                else if (sel == REG_MASK) rd_mux = mask_all[c];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (rd_req) state_d = PORT_RESP;
            PORT_RESP: state_d = rd_req ? PORT_RESP : PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= rd_mux;
    end

    always_comb begin
        rd_valid = (state_q == PORT_RESP);
    end

    // R9: a response only follows a read request
    a_r9_resp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));
    // R10: at most one bank is written per cycle
    a_r10_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_we | mask_we));
endmodule

// File: rtl/dbell_unit.sv
module dbell_unit #(
    parameter int NUM_CPUS = 4,
    parameter int DB_W     = 32,
    parameter int TGT_LSB  = 8,
    parameter int IPI_LO   = 0,
    parameter int IPI_HI   = 7,
    parameter int MSI_LO   = 16,
    parameter int MSI_HI   = 31,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_we,
    input  logic [DB_W-1:0]     trig_wdata,
    input  logic                reg_valid,
    input  logic                reg_write,
    input  logic [3:0]          reg_addr,
    input  logic [CPU_W-1:0]    reg_cpu,
    input  logic [DB_W-1:0]     reg_wdata,
    output logic                reg_rvalid,
    output logic [DB_W-1:0]     reg_rdata,
    output logic [NUM_CPUS-1:0] ipi_irq,
    output logic [NUM_CPUS-1:0] msi_irq
);
    function automatic logic [DB_W-1:0] span(int lo, int hi);
        logic [DB_W-1:0] v;
        for (int b = 0; b < DB_W; b++) v[b] = (b >= lo) && (b <= hi);
        return v;
    endfunction

    localparam logic [DB_W-1:0] IPI_SPAN = span(IPI_LO, IPI_HI);
    localparam logic [DB_W-1:0] MSI_SPAN = span(MSI_LO, MSI_HI);

    logic [NUM_CPUS-1:0][DB_W-1:0] set_vec;
    logic [NUM_CPUS-1:0][DB_W-1:0] cause_all;
    logic [NUM_CPUS-1:0][DB_W-1:0] mask_all;
    logic [NUM_CPUS-1:0]           cause_we;
    logic [NUM_CPUS-1:0]           mask_we;

    dbell_trig_decode #(
        .NUM_CPUS(NUM_CPUS), .DB_W(DB_W), .TGT_LSB(TGT_LSB),
        .GROUP_SPAN(IPI_SPAN | MSI_SPAN)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .trig_we(trig_we),
        .trig_wdata(trig_wdata), .set_vec(set_vec)
    );

    dbell_regport #(.NUM_CPUS(NUM_CPUS), .DB_W(DB_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .req_valid(reg_valid), .req_write(reg_write),
        .req_addr(reg_addr), .req_cpu(reg_cpu),
        .cause_all(cause_all), .mask_all(mask_all),
        .cause_we(cause_we), .mask_we(mask_we),
        .rd_valid(reg_rvalid), .rd_data(reg_rdata)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
        dbell_cpu_bank #(.DB_W(DB_W), .IPI_SPAN(IPI_SPAN), .MSI_SPAN(MSI_SPAN)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .set_i(set_vec[c]), .cause_we(cause_we[c]), .mask_we(mask_we[c]),
            .wdata(reg_wdata),
            .cause_o(cause_all[c]), .mask_o(mask_all[c]),
            .ipi_irq_o(ipi_irq[c]), .msi_irq_o(msi_irq[c])
        );

        // R7: the IPI line only rises after a trigger or a register write
        a_r7_ipi_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ipi_irq[c]) |-> $past(trig_we || (reg_valid && reg_write)));
        // R8: the MSI line only rises after a trigger or a register write
        a_r8_msi_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(msi_irq[c]) |-> $past(trig_we || (reg_valid && reg_write)));
    end
endmodule

// File: tb/dbell_unit_tb.sv
module dbell_unit_tb;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_we = 1'b0;
    logic [31:0] trig_wdata = '0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [1:0]  reg_cpu = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rvalid;
    logic [31:0] reg_rdata;
    logic [NC-1:0] ipi_irq, msi_irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_cause [NC];
    logic [31:0] m_mask  [NC];

    always #2 clk = ~clk;

    dbell_unit u_dut (
        .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_wdata(trig_wdata),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_cpu(reg_cpu), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata), .ipi_irq(ipi_irq), .msi_irq(msi_irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit in_grp(int n);
        return (n <= 7) || (n >= 16 && n <= 31);
    endfunction

    task automatic trig(int n, logic [3:0] map);
        trig_we = 1'b1;
        trig_wdata = {20'h0, map, 3'b000, 5'(n)};
        @(negedge clk);
        trig_we = 1'b0;
        if (in_grp(n))
            for (int c = 0; c < NC; c++) if (map[c]) m_cause[c] |= (32'h1 << n);
    endtask

    task automatic regwr(int cpu, logic [3:0] addr, logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b1; reg_cpu = 2'(cpu);
        reg_addr = addr; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        if (addr == 4'h8) m_cause[cpu] &= d;
        else if (addr == 4'hC) m_mask[cpu] = d;
    endtask

    task automatic regrd(string req, int cpu, logic [3:0] addr, logic [31:0] exp);
        reg_valid = 1'b1; reg_write = 1'b0; reg_cpu = 2'(cpu); reg_addr = addr;
        @(negedge clk);
        reg_valid = 1'b0;
        chk({req, " rvalid"}, 32'(reg_rvalid), 32'd1);
        chk(req, reg_rdata, exp);
    endtask

    task automatic lines(string req);
        for (int c = 0; c < NC; c++) begin
            chk({req, " R7 ipi"}, 32'(ipi_irq[c]), 32'(|(m_cause[c] & m_mask[c] & 32'h0000_00FF)));
            chk({req, " R8 msi"}, 32'(msi_irq[c]), 32'(|(m_cause[c] & m_mask[c] & 32'hFFFF_0000)));
        end
    endtask

    task automatic all_regs(string req);
        for (int c = 0; c < NC; c++) begin
            regrd(req, c, 4'h8, m_cause[c]);
            regrd(req, c, 4'hC, m_mask[c]);
        end
        lines(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin m_cause[c] = '0; m_mask[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rvalid", 32'(reg_rvalid), 32'd0);
        chk("R1 ipi", 32'(ipi_irq), 32'd0);
        chk("R1 msi", 32'(msi_irq), 32'd0);
        all_regs("R1");

        // R2 R3: every doorbell number against every target bitmap
        for (int c = 0; c < NC; c++) regwr(c, 4'hC, 32'hFFFF_FFFF);
        for (int n = 0; n < 32; n++) begin
            for (int m = 0; m < 16; m++) begin
                for (int c = 0; c < NC; c++) regwr(c, 4'h8, 32'h0);
                trig(n, 4'(m));
                lines(in_grp(n) ? "R2 sweep" : "R3 sweep");
                for (int c = 0; c < NC; c++)
                    regrd(in_grp(n) ? "R2 cause" : "R3 cause", c, 4'h8, m_cause[c]);
            end
        end

        // R4: ones written never set, zeros clear only their bit
        for (int c = 0; c < NC; c++) regwr(c, 4'h8, 32'h0);
        regwr(0, 4'h8, 32'hFFFF_FFFF);
        regrd("R4 ones keep zero", 0, 4'h8, 32'h0);
        trig(3, 4'hF); trig(20, 4'hF); trig(31, 4'hF);
        regwr(2, 4'h8, ~(32'h1 << 20));
        all_regs("R4 single clear");

        // R5: same-cycle set and clear of one bit
        trig_we = 1'b1; trig_wdata = {20'h0, 4'b0010, 3'b000, 5'd5};
        reg_valid = 1'b1; reg_write = 1'b1; reg_cpu = 2'd1; reg_addr = 4'h8; reg_wdata = 32'h0;
        @(negedge clk);
        trig_we = 1'b0; reg_valid = 1'b0; reg_write = 1'b0;
        m_cause[1] = 32'h1 << 5;
        regrd("R5 set wins", 1, 4'h8, 32'h0000_0020);

        // R6 R7 R8 R9: mask patterns, raw cause read regardless of mask
        for (int c = 0; c < NC; c++) regwr(c, 4'h8, 32'h0);
        trig(2, 4'hF); trig(17, 4'hF);
        for (int p = 0; p < 8; p++) begin
            logic [31:0] pat;
            pat = {p[2] ? 16'h0002 : 16'h0000, p[1] ? 8'h80 : 8'h00, p[0] ? 8'h04 : 8'h00};
            for (int c = 0; c < NC; c++) regwr(c, 4'hC, pat ^ (c[0] ? 32'h0000_0004 : 32'h0));
            all_regs("R6 R9 mask pattern");
        end

        // R9: unknown offsets read zero and ignore writes
        regwr(3, 4'h4, 32'hFFFF_FFFF);
        regwr(3, 4'h0, 32'h0);
        regrd("R9 bad offset", 3, 4'h4, 32'h0);
        all_regs("R9 ignored write");

        // R10: banking touches only the selected CPU
        for (int c = 0; c < NC; c++) regwr(c, 4'hC, 32'hFFFF_00FF);
        trig(6, 4'hF); trig(30, 4'hF);
        regwr(2, 4'h8, 32'h0);
        regwr(1, 4'hC, 32'h0000_0040);
        all_regs("R10 banking");

        // R11: zero mask and cause quiets the CPU
        regwr(0, 4'hC, 32'h0);
        regwr(0, 4'h8, 32'h0);
        chk("R11 ipi", 32'(ipi_irq[0]), 32'd0);
        chk("R11 msi", 32'(msi_irq[0]), 32'd0);
        all_regs("R11 quiesce");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule